// File: doc/BRIEF.md
# Split Two-Section Binary Counter with Paired Clear

A four-bit up counter split into two sections that can run on their own or be chained. The low section is one toggle stage that halves the rate of its input pulse stream. The high section is three toggle stages in cascade that divide their own pulse stream by eight. Each stage changes state when its input pulse line goes from 1 to 0.

The whole block runs on one master clock. Each section's pulse line is sampled on that clock, and a 1-to-0 transition seen between two samples counts as one falling edge. Everything that a ripple chain would do in one settled step is resolved within a single master cycle: the carry from stage to stage, and any clear fed back from the count. So the registered count only ever shows settled values.

Two clear requests act only together. When both are high, all four stages go to zero. In chained mode the high section takes its pulses from bit 0 instead of its own pulse line, which gives a modulo-16 count. In decade mode the clear pair is driven from count bits 1 and 3 instead of the external requests, so the sequence is cut short after 9. An extra output flags the last state of the active sequence.

Top module: `split_ripple_counter`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, the count becomes 0 and `at_last` is 0 after that edge. Edge history is also cleared, so the first sample after reset is never taken as a falling edge.
- R2: Bit 0 (`count[0]`) inverts once for each falling edge of `pulse_a`, one `clk` cycle after the low sample. A rising edge of `pulse_a`, or a line held at either level, leaves it unchanged.
- R3: With `cfg_chain` = 0, bits 3:1 form a three-bit binary count, with `count[1]` as its LSB. It advances by one for each falling edge of `pulse_b` and wraps from 7 to 0 without touching bit 0.
- R4: With `cfg_chain` = 1, `pulse_b` is ignored. Bits 3:1 advance whenever bit 0 goes from 1 to 0 in the same cycle. The full count runs 0 to 15 and is back at 0 after the 16th falling edge of `pulse_a`.
- R5: With `cfg_decade` = 0, `zero_req_a` and `zero_req_b` both high at a clock edge force the count to 0. This wins over any pulse edge seen in that cycle. Either request alone has no effect.
- R6: With `cfg_decade` = 1, the clear pair is taken from `count[1]` and `count[3]`, and the external requests are ignored. A next value with both of those bits set is replaced by 0 in the same cycle. The chained count runs 0 to 9 and is back at 0 after the 10th pulse. A settled count entered at 9 or below never shows 10 to 15.
- R7: `at_last` is 1 exactly when the count is 15 with `cfg_decade` = 0, or when the count is 9 with `cfg_decade` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_chain | input | 1 | 1: high section is clocked by bit 0 falling; 0: by `pulse_b` |
| cfg_decade | input | 1 | 1: clear pair fed back from count bits 1 and 3 |
| pulse_a | input | 1 | Pulse line of the low section, sampled on `clk` |
| pulse_b | input | 1 | Pulse line of the high section, sampled on `clk` |
| zero_req_a | input | 1 | First clear request, effective only together with the second |
| zero_req_b | input | 1 | Second clear request |
| count | output | 4 | Counter value, bit 0 = low section, bits 3:1 = high section |
| at_last | output | 1 | Terminal-state flag of the active sequence |

## Verification
Two collisions matter here. The first is a paired external clear in the same cycle as a falling edge on both pulse lines: the bench drives both and expects zero, not the incremented value. The second is the decade wrap, where the carry from bit 0 into the high section and the feedback clear land in the same cycle: the bench walks the chained count through several full decades and expects 9 to be followed directly by 0, with no 10 ever visible. A reference model in the bench, built from integers, predicts the count and terminal flag on every clock and is compared with both outputs.

// File: rtl/scnt_pkg.sv
// Package: shared types for the split counter.
// Assumes: nothing beyond standard SystemVerilog.
package scnt_pkg;

    // Number of independently clocked sections in the counter.
    localparam int unsigned SECT_CNT = 2;

    // Per-stage control: toggle request and synchronous clear.
    typedef struct packed {
        logic tick;
        logic clr;
    } stage_ctl_t;

endpackage

// File: rtl/scnt_fall_detect.sv
// Module: scnt_fall_detect
// Turns each sampled pulse line into a one-cycle event on a 1-to-0 transition.
// Assumes: pulse lines are already synchronous to clk; history clears on reset.
module scnt_fall_detect #(
    parameter int unsigned LINES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lvl,
    output logic [LINES-1:0] fall
);

    logic [LINES-1:0] prev_q;

    // Remember last sampled level of every line.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    // Falling edge event when previous sample high and current low.
    assign fall = prev_q & ~lvl;

    for (genvar g = 0; g < LINES; g++) begin : g_chk
        AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            fall[g] |=> !fall[g]); // R2
    end

endmodule

// File: rtl/scnt_toggle_stage.sv
// Module: scnt_toggle_stage
// One JK stage with J=K=1: inverts on a tick, cleared by a synchronous clear.
// Assumes: clear has priority over tick; fall reports a 1-to-0 step from the tick.
module scnt_toggle_stage
    import scnt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  stage_ctl_t ctl,
    output logic       q,
    output logic       q_nxt,
    output logic       fall
);

    // Next state before any clear is applied.
    assign q_nxt = q ^ ctl.tick;
    // Stage output drops from 1 to 0 this cycle: carry to the next stage.
    assign fall  = q & ctl.tick;

    // Stage register with reset and clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= 1'b0;
        else if (ctl.clr) q <= 1'b0;
        else              q <= q_nxt;
    end

    AST_STAGE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.tick && !ctl.clr) |=> (q != $past(q))); // R2
    AST_STAGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.clr |=> !q); // R5

endmodule

// File: rtl/scnt_clear_gate.sv
// Module: scnt_clear_gate
// Forms the clear for all stages: AND of the external pair, or the AND of two
// next-state bits when feedback mode is on.
// Assumes: TAP_LO and TAP_HI are distinct bit indices below W.
module scnt_clear_gate #(
    parameter int unsigned W      = 4,
    parameter int unsigned TAP_LO = 1,
    parameter int unsigned TAP_HI = 3
) (
    input  logic         cfg_decade,
    input  logic         zero_req_a,
    input  logic         zero_req_b,
    input  logic [W-1:0] q_nxt,
    output logic         clr
);

    logic pair_a;
    logic pair_b;

    // Select the source of each clear input, then AND them.
    always_comb begin
        pair_a = cfg_decade ? q_nxt[TAP_LO] : zero_req_a;
        pair_b = cfg_decade ? q_nxt[TAP_HI] : zero_req_b;
        clr    = pair_a & pair_b;
    end

endmodule

// File: rtl/split_ripple_counter.sv
// Module: split_ripple_counter
// Four-bit counter split into a low section and a high section with separate
// pulse lines, carry resolved in one master cycle, paired clear, decade feedback.
// Assumes: pulse lines synchronous to clk; synchronous active-low reset.
module split_ripple_counter
    import scnt_pkg::*;
#(
    parameter int unsigned A_BITS = 1,
    parameter int unsigned B_BITS = 3,
    parameter int unsigned TAP_LO = 1,
    parameter int unsigned TAP_HI = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_chain,
    input  logic                     cfg_decade,
    input  logic                     pulse_a,
    input  logic                     pulse_b,
    input  logic                     zero_req_a,
    input  logic                     zero_req_b,
    output logic [A_BITS+B_BITS-1:0] count,
    output logic                     at_last
);

    localparam int unsigned W = A_BITS + B_BITS;
    localparam logic [W-1:0] FULL_TERM = W'((1 << W) - 1);
    localparam logic [W-1:0] DEC_TERM  = W'((1 << TAP_LO) + (1 << TAP_HI) - 1);

    logic [SECT_CNT-1:0] sect_fall;
    logic [W-1:0]        tick;
    logic [W-1:0]        stage_fall;
    logic [W-1:0]        q_nxt;
    logic                clr_all;

    scnt_fall_detect #(.LINES(SECT_CNT)) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({pulse_b, pulse_a}),
        .fall  (sect_fall)
    );

    // Tick routing: first stage of each section from its pulse line or the
    // carry, remaining stages from the previous stage falling.
    for (genvar i = 0; i < W; i++) begin : g_tick
        if (i == 0) begin : g_first
            assign tick[i] = sect_fall[0];
        end else if (i == A_BITS) begin : g_join
            assign tick[i] = cfg_chain ? stage_fall[i-1] : sect_fall[1];
        end else begin : g_cascade
            assign tick[i] = stage_fall[i-1];
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_stage
        stage_ctl_t ctl;
        assign ctl.tick = tick[i];
        assign ctl.clr  = clr_all;
        scnt_toggle_stage u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .ctl   (ctl),
            .q     (count[i]),
            .q_nxt (q_nxt[i]),
            .fall  (stage_fall[i])
        );
    end

    scnt_clear_gate #(.W(W), .TAP_LO(TAP_LO), .TAP_HI(TAP_HI)) u_clear (
        .cfg_decade (cfg_decade),
        .zero_req_a (zero_req_a),
        .zero_req_b (zero_req_b),
        .q_nxt      (q_nxt),
        .clr        (clr_all)
    );

    // Terminal flag for the active sequence.
    assign at_last = cfg_decade ? (count == DEC_TERM) : (count == FULL_TERM);

    AST_CLEAR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_decade && zero_req_a && zero_req_b) |=> (count == '0)); // R5
    AST_DECADE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_decade && count <= DEC_TERM) |=> (count <= DEC_TERM)); // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sect_fall == '0 && !(!cfg_decade && zero_req_a && zero_req_b)
         && (!cfg_decade || count <= DEC_TERM)) |=> $stable(count)); // R2
    AST_MSB_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        stage_fall[W-1] |=> !count[W-1]); // R3

endmodule

// File: tb/split_ripple_counter_bench.sv
`timescale 1ns/1ps
module split_ripple_counter_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_chain = 1'b0;
    logic       cfg_decade = 1'b0;
    logic       pulse_a = 1'b0;
    logic       pulse_b = 1'b0;
    logic       zero_req_a = 1'b0;
    logic       zero_req_b = 1'b0;
    logic [3:0] count;
    logic       at_last;

    int checks = 0;
    int errors = 0;
    int m_cnt = 0;
    bit m_pa = 0;
    bit m_pb = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    split_ripple_counter u_split_ripple_counter (
        .clk (clk), .rst_n (rst_n), .cfg_chain (cfg_chain), .cfg_decade (cfg_decade),
        .pulse_a (pulse_a), .pulse_b (pulse_b),
        .zero_req_a (zero_req_a), .zero_req_b (zero_req_b),
        .count (count), .at_last (at_last)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Behavioural model of one master clock edge.
    task automatic model_edge();
        bit fa, fb, carry, adv;
        int n;
        if (!rst_n) begin
            m_cnt = 0; m_pa = 0; m_pb = 0;
        end else begin
            fa = m_pa && !pulse_a;
            fb = m_pb && !pulse_b;
            m_pa = pulse_a;
            m_pb = pulse_b;
            n = m_cnt;
            if (cfg_decade || !(zero_req_a && zero_req_b)) begin
                carry = 0;
                if (fa) begin
                    carry = (n % 2) == 1;
                    n = n ^ 1;
                end
                adv = cfg_chain ? carry : fb;
                if (adv) n = (n % 2) + (((n / 2) + 1) % 8) * 2;
                if (cfg_decade && ((n / 2) % 2 == 1) && (n / 8 == 1)) n = 0;
            end else begin
                n = 0;
            end
            m_cnt = n;
        end
    endtask

    // Drive at negedge, model at posedge, compare at next negedge.
    task automatic step(input bit a, input bit b, input bit x, input bit y);
        bit exp_last;
        pulse_a = a; pulse_b = b; zero_req_a = x; zero_req_b = y;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(count == 4'(m_cnt), tag, int'(count), m_cnt);
        exp_last = cfg_decade ? (m_cnt == 9) : (m_cnt == 15);
        check(at_last == exp_last, "R7", int'(at_last), int'(exp_last));
        if (cfg_decade) check(count <= 4'd9, "R6", int'(count), 9);
    endtask

    task automatic pulse_low(input int n);
        for (int i = 0; i < n; i++) begin
            step(1, 0, 0, 0);
            step(0, 0, 0, 0);
        end
    endtask

    task automatic pulse_high(input int n);
        for (int i = 0; i < n; i++) begin
            step(0, 1, 0, 0);
            step(0, 0, 0, 0);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tag = "R1";
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        check(count == 4'd0, "R1", int'(count), 0);
        check(at_last == 1'b0, "R1", int'(at_last), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R2: low section alone, levels held and rising edges do nothing.
        tag = "R2";
        cfg_chain = 0; cfg_decade = 0;
        step(1, 0, 0, 0); step(1, 0, 0, 0);
        check(count == 4'd0, "R2", int'(count), 0);
        step(0, 0, 0, 0);
        check(count == 4'd1, "R2", int'(count), 1);
        step(0, 0, 0, 0); step(0, 0, 0, 0);
        pulse_low(3);

        // R3: high section on its own line, wraps bits 3:1.
        tag = "R3";
        do_reset();
        tag = "R3";
        pulse_high(7);
        check(count == 4'd14, "R3", int'(count), 14);
        pulse_high(1);
        check(count == 4'd0, "R3", int'(count), 0);
        pulse_low(1);
        pulse_high(9);

        // R4: chained modulo-16, pulse_b ignored.
        do_reset();
        tag = "R4";
        cfg_chain = 1;
        pulse_low(15);
        check(count == 4'd15, "R4", int'(count), 15);
        check(at_last == 1'b1, "R7", int'(at_last), 1);
        pulse_high(3);
        check(count == 4'd15, "R4", int'(count), 15);
        pulse_low(1);
        check(count == 4'd0, "R4", int'(count), 0);
        pulse_low(21);

        // R5: single request no effect, pair clears, pair beats pulse edges.
        tag = "R5";
        step(0, 0, 1, 0); step(0, 0, 0, 1);
        check(count == 4'd5, "R5", int'(count), 5);
        step(1, 1, 0, 0);
        step(0, 0, 1, 1);
        check(count == 4'd0, "R5", int'(count), 0);
        pulse_low(6);
        step(1, 1, 0, 0);
        step(0, 0, 1, 1);
        check(count == 4'd0, "R5", int'(count), 0);
        cfg_chain = 0;
        pulse_low(1); pulse_high(2);
        step(1, 1, 0, 0);
        step(0, 0, 1, 1);
        check(count == 4'd0, "R5", int'(count), 0);

        // R6: decade feedback, external pair ignored.
        do_reset();
        tag = "R6";
        cfg_chain = 1; cfg_decade = 1;
        pulse_low(9);
        check(count == 4'd9, "R6", int'(count), 9);
        pulse_low(1);
        check(count == 4'd0, "R6", int'(count), 0);
        pulse_low(4);
        step(0, 0, 1, 1);
        check(count == 4'd4, "R6", int'(count), 4);
        pulse_low(33);
        cfg_chain = 0;
        pulse_high(6); pulse_low(3); pulse_high(5);

        // R1: reset in mid-count.
        cfg_decade = 0; cfg_chain = 1;
        pulse_low(5);
        do_reset();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule